// File: doc/BRIEF.md
# Capacitive Key Touch Detector

This block decides, for one sensing channel, whether a capacitive key is touched. An acquisition front end measures the key once per acquisition period. It subtracts the channel reference and passes the resulting signed delta to this block over a valid/ready stream. A positive delta points in the touch direction.

The block takes a touch only after a run of consecutive strong samples. It releases at a lower level than the one needed to enter, so there is hysteresis between the two. It also measures how long a key stays touched. A key held in detect for too long is treated as an obstruction: the block drops the detection and raises a one-cycle recalibration request for the reference logic. A chip instantiates one copy per key.

The stream rules are as follows. A delta is taken on a clock edge where `acq_valid` and `acq_ready` are both high. `acq_ready` is low only while `calibrate` is high. During that time the producer must hold its sample until `calibrate` falls. While the channel is disabled, samples are still accepted and then discarded.

Top module: `key_detect_chan`

## Requirements
- R1: An accepted delta of at least ENTER_TH (default 10) counts toward confirmation. A delta of ENTER_TH-1 or less does not count, and negative deltas never count.
- R2: While in detect, an accepted delta below EXIT_TH (default 8) clears detect on that edge with no integration. Deltas of EXIT_TH and above keep the key in detect.
- R3: Detect is set on the edge that accepts the CONFIRM_N-th (default 5) consecutive counting delta, and is visible in the following cycle.
- R4: An accepted delta below ENTER_TH before confirmation completes restarts the count from zero.
- R5: Each accepted delta that keeps the key in detect adds the acquisition period in ms to an on-time total. When the total reaches MAX_ON_MS, detect clears and `recal_req` is high for exactly one cycle.
- R6: `key_out_n` is low exactly while `detect` is high.
- R7: While `chan_disable` is high, detect, the confirmation count and the on-time total are held at zero, and accepted deltas have no effect.
- R8: When `calibrate` is high, the confirmation count, detect and the on-time total are cleared on the next edge, and `acq_ready` is low during that time.
- R9: `fast_mode` high selects a period of FAST_MS (default 16 ms). Low selects SLOW_MS (default 64 ms).
- R10: After reset, detect and `recal_req` are low and `key_out_n` is high.
- R11: Cycles without an accepted sample leave detect, the confirmation count and the on-time total unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_valid | input | 1 | Delta sample offered |
| acq_ready | output | 1 | Sample can be taken (low during calibrate) |
| acq_delta | input | DELTA_W | Signed count delta, positive toward touch |
| fast_mode | input | 1 | 1 = fast acquisition period, 0 = slow |
| chan_disable | input | 1 | Forces the channel untouched and idle |
| calibrate | input | 1 | Clears all detection state |
| key_out_n | output | 1 | Active-low touched output |
| detect | output | 1 | Key declared touched |
| recal_req | output | 1 | One-cycle recalibration request |

## Verification
Deltas are driven exactly at the threshold edges: 9 against 10 on entry, and 7 against 8 on exit. This separates an off-by-one compare from a correct one. Runs of four strong samples broken by one weak sample tell a counter that restarts from one that merely pauses. Idle gaps inside a run show that the run is counted in samples and not in clock cycles. Long holds in fast and in slow mode give different tick counts to timeout. A chip-level `calibrate` or `chan_disable` is applied in the middle of a run and in the middle of a hold, to show that every piece of state is cleared.

// File: rtl/kd_pkg.sv
package kd_pkg;
  function automatic int unsigned kd_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/kd_level_cmp.sv
module kd_level_cmp #(
  parameter int DELTA_W  = 16,
  parameter int ENTER_TH = 10,
  parameter int EXIT_TH  = 8
) (
  input  logic signed [DELTA_W-1:0] delta,
  output logic                      at_enter,
  output logic                      below_exit
);
  localparam logic signed [DELTA_W-1:0] ENTER_V = DELTA_W'(ENTER_TH);
  localparam logic signed [DELTA_W-1:0] EXIT_V  = DELTA_W'(EXIT_TH);

  always_comb begin
    at_enter   = (delta >= ENTER_V);
    below_exit = (delta < EXIT_V);
  end
endmodule

// File: rtl/kd_ontimer.sv
module kd_ontimer
  import kd_pkg::*;
#(
  parameter int MAX_ON_MS = 30000,
  parameter int FAST_MS   = 16,
  parameter int SLOW_MS   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic in_detect,
  input  logic below_exit,
  input  logic fast_mode,
  output logic overtime
);
  localparam int ON_W = kd_bits(MAX_ON_MS + SLOW_MS);

  logic [ON_W-1:0] on_ms;
  logic [ON_W-1:0] per_ms;
  logic [ON_W-1:0] sum_ms;
  logic            holding;

  always_comb begin
    per_ms   = fast_mode ? ON_W'(FAST_MS) : ON_W'(SLOW_MS);
    sum_ms   = on_ms + per_ms;
    holding  = step && in_detect && !below_exit;
    overtime = holding && (sum_ms >= ON_W'(MAX_ON_MS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_ms <= '0;
    end else if (clr) begin
      on_ms <= '0;
    end else if (step) begin
      if (holding && !overtime) on_ms <= sum_ms;
      else                      on_ms <= '0;
    end
  end

  assert_timer_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    on_ms < ON_W'(MAX_ON_MS));
  assert_timer_idle_when_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !in_detect) |=> (on_ms == '0));
  assert_timer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(on_ms));
endmodule

// File: rtl/kd_confirm.sv
module kd_confirm
  import kd_pkg::*;
#(
  parameter int CONFIRM_N = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic at_enter,
  input  logic below_exit,
  input  logic overtime,
  output logic detect,
  output logic recal_req
);
  localparam int CNT_W = kd_bits(CONFIRM_N);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] run_next;

  assign run_next = run_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      detect    <= 1'b0;
      recal_req <= 1'b0;
    end else if (clr) begin
      run_cnt   <= '0;
      detect    <= 1'b0;
      recal_req <= 1'b0;
    end else begin
      recal_req <= 1'b0;
      if (step) begin
        if (!detect) begin
          if (!at_enter) begin
            run_cnt <= '0;
          end else if (run_next >= CNT_W'(CONFIRM_N)) begin
            run_cnt <= '0;
            detect  <= 1'b1;
          end else begin
            run_cnt <= run_next;
          end
        end else if (below_exit) begin
          detect <= 1'b0;
        end else if (overtime) begin
          detect    <= 1'b0;
          recal_req <= 1'b1;
          run_cnt   <= '0;
        end
      end
    end
  end

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < CNT_W'(CONFIRM_N));
  assert_weak_sample_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_enter && !detect) |=> (run_cnt == '0));
  assert_recal_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> !recal_req);
  assert_recal_drops_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> !detect);
endmodule

// File: rtl/key_detect_chan.sv
module key_detect_chan
  import kd_pkg::*;
#(
  parameter int DELTA_W   = 16,
  parameter int ENTER_TH  = 10,
  parameter int EXIT_TH   = 8,
  parameter int CONFIRM_N = 5,
  parameter int MAX_ON_MS = 30000,
  parameter int FAST_MS   = 16,
  parameter int SLOW_MS   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acq_valid,
  output logic               acq_ready,
  input  logic [DELTA_W-1:0] acq_delta,
  input  logic               fast_mode,
  input  logic               chan_disable,
  input  logic               calibrate,
  output logic               key_out_n,
  output logic               detect,
  output logic               recal_req
);
  logic signed [DELTA_W-1:0] delta_s;
  logic at_enter, below_exit, overtime, clr, step;

  assign delta_s   = $signed(acq_delta);
  assign acq_ready = !calibrate;
  assign clr       = chan_disable || calibrate;
  assign step      = acq_valid && acq_ready;
  assign key_out_n = !detect;

  kd_level_cmp #(
    .DELTA_W(DELTA_W), .ENTER_TH(ENTER_TH), .EXIT_TH(EXIT_TH)
  ) u_cmp (
    .delta(delta_s), .at_enter(at_enter), .below_exit(below_exit)
  );

  kd_ontimer #(
    .MAX_ON_MS(MAX_ON_MS), .FAST_MS(FAST_MS), .SLOW_MS(SLOW_MS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .in_detect(detect),
    .below_exit(below_exit), .fast_mode(fast_mode), .overtime(overtime)
  );

  kd_confirm #(
    .CONFIRM_N(CONFIRM_N)
  ) u_conf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .at_enter(at_enter),
    .below_exit(below_exit), .overtime(overtime), .detect(detect),
    .recal_req(recal_req)
  );

  assert_entry_needs_strong_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect) |-> $past(step && at_enter && !clr));
  assert_release_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && step && below_exit) |=> !detect);
  assert_disable_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_disable |=> (!detect && !recal_req));
  assert_calibrate_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    calibrate |=> !detect);
  assert_no_ready_in_cal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    calibrate |-> !acq_ready);
endmodule

// File: tb/key_detect_chan_tb_top.sv
`timescale 1ns/1ps
module key_detect_chan_tb_top;
  localparam int MAXON = 200;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acq_valid = 1'b0, fast_mode = 1'b1, chan_disable = 1'b0, calibrate = 1'b0;
  logic [15:0] acq_delta = '0;
  logic acq_ready, key_out_n, detect, recal_req;

  key_detect_chan #(.MAX_ON_MS(MAXON)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_ready(acq_ready),
    .acq_delta(acq_delta), .fast_mode(fast_mode), .chan_disable(chan_disable),
    .calibrate(calibrate), .key_out_n(key_out_n), .detect(detect), .recal_req(recal_req)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R10";
  int m_cnt = 0, m_on = 0;
  bit m_det = 0, m_recal = 0;
  bit done = 0;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("detect", int'(detect), int'(m_det));
    chk("key_out_n", int'(key_out_n), int'(!m_det));
    chk("recal_req", int'(recal_req), int'(m_recal));
    chk("acq_ready", int'(acq_ready), int'(!calibrate));
  endtask

  // reference model: next state from the inputs sampled at the coming edge
  task automatic model_step();
    int d, per;
    d = int'($signed(acq_delta));
    per = fast_mode ? 16 : 64;
    m_recal = 0;
    if (!rst_n || chan_disable || calibrate) begin
      m_cnt = 0; m_det = 0; m_on = 0;
    end else if (acq_valid) begin
      if (!m_det) begin
        m_on = 0;
        if (d >= 10) begin
          m_cnt++;
          if (m_cnt >= 5) begin m_det = 1; m_cnt = 0; end
        end else m_cnt = 0;
      end else if (d < 8) begin
        m_det = 0; m_on = 0;
      end else begin
        m_on += per;
        if (m_on >= MAXON) begin m_det = 0; m_on = 0; m_cnt = 0; m_recal = 1; end
      end
    end
  endtask

  // one clock: compare, set inputs, predict
  task automatic cyc(input bit v, input int d);
    @(negedge clk);
    compare_all();
    acq_valid = v;
    acq_delta = 16'(d);
    model_step();
  endtask

  task automatic run(input int n, input int d);
    for (int i = 0; i < n; i++) cyc(1'b1, d);
  endtask

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 100000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) cyc(1'b0, 0);
    @(negedge clk); rst_n = 1'b1; model_step();
    cyc(1'b0, 0);

    // R1: delta 9 never confirms; negatives never count
    cur_req = "R1";
    run(8, 9); run(6, -20); cyc(1'b0, 0);

    // R3 + R6: five at exactly 10 confirm
    cur_req = "R3";
    run(5, 10); cyc(1'b0, 0); cyc(1'b0, 0);

    // R2: 8 holds, 7 releases immediately
    cur_req = "R2";
    run(3, 8); run(1, 7); cyc(1'b0, 0);

    // R4: four strong then a weak one restarts
    cur_req = "R4";
    run(4, 12); run(1, 9); run(4, 12); cyc(1'b0, 0); run(1, 12); cyc(1'b0, 0);
    run(1, 0);

    // R11: idle gaps inside a run do not break it
    cur_req = "R11";
    for (int i = 0; i < 5; i++) begin run(1, 15); cyc(1'b0, 3); cyc(1'b0, 3); end
    cyc(1'b0, 0);

    // R5 + R9 fast: hold until timeout (200 ms / 16 ms = 13 samples)
    cur_req = "R5";
    fast_mode = 1'b1;
    run(16, 30); cyc(1'b0, 0); cyc(1'b0, 0);

    // R9 slow: 4 samples at 64 ms
    cur_req = "R9";
    fast_mode = 1'b0;
    run(5, 30); run(5, 30); cyc(1'b0, 0); cyc(1'b0, 0);
    fast_mode = 1'b1;

    // R8: calibrate during a run and during a hold
    cur_req = "R8";
    run(3, 20);
    @(negedge clk); compare_all(); calibrate = 1'b1; model_step();
    @(negedge clk); compare_all(); calibrate = 1'b0; acq_valid = 1'b1; acq_delta = 16'd20; model_step();
    run(2, 20); run(6, 20);
    @(negedge clk); compare_all(); calibrate = 1'b1; model_step();
    @(negedge clk); compare_all(); calibrate = 1'b0; acq_valid = 1'b0; model_step();
    cyc(1'b0, 0);

    // R7: disable blocks detection and clears a held key
    cur_req = "R7";
    run(5, 20);
    @(negedge clk); compare_all(); chan_disable = 1'b1; model_step();
    run(10, 40);
    @(negedge clk); compare_all(); chan_disable = 1'b0; acq_valid = 1'b0; model_step();
    run(4, 40); cyc(1'b0, 0);
    run(1, 40); cyc(1'b0, 0);
    run(2, 0); cyc(1'b0, 0);

    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule